// File: doc/BRIEF.md
# I/O MMU Control and Fault Register Block

This block is the 32-bit software-visible register file of an I/O memory management unit. A simple single-cycle bus port carries a word address, a write strobe, a read strobe and write data, and returns read data from the same cycle. Each defined register applies its own write mask and, in some cases, a set of bits that are always one. The translation-enable bit, the page-table base and a DVMA window base are brought out to the translation logic. The window base is decoded from a 3-bit range code in the control register.

The translation logic reports a failed access on a one-cycle event port. The block captures a status word and the page-aligned failing address into two fault registers and raises a level interrupt. Software clears the interrupt as a side effect of reading or writing either fault register. Word addresses that hold no defined register act as plain 32-bit storage. The flush registers only store what is written; no flush action is taken.

Top module: `iommu_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, reads return: control = IMPL_VER in bits 31:24 and zero elsewhere; arbitration enable = 0x00000008; fault status = 0x00800000; arbiter enable = 0x00000003; mask ID = 0x23000000; all other defined registers = 0. The outputs win_base, pt_base, xlate_en and irq are all 0.
- R2: A write to control (word 0x000) keeps only data bits 0, 2, 3 and 4 (mask 0x0000001D). Bits 31:24 always read as IMPL_VER. xlate_en follows bit 0.
- R3: A control write loads win_base from the range code in data bits 4:2. Codes 0..7 give 0xFF000000, 0xFE000000, 0xFC000000, 0xF8000000, 0xF0000000, 0xE0000000, 0xC0000000 and 0x80000000. The output changes on the edge that takes the write.
- R4: The page-table base (word 0x001, also driven on pt_base) keeps mask 0x07FFFC00. The two flush registers (words 0x002 and 0x003) store all 32 written bits.
- R5: A write to fault status (word 0x010) keeps mask 0xFF0FFFFF and sets bit 23. A write to fault address (word 0x011) stores all 32 bits.
- R6: The arbiter enable register (word 0x012) keeps mask 0x801F000F with bit 0 forced to one. The arbitration enable register (word 0x013) keeps mask 0x001F0000 with bit 3 forced to one.
- R7: Each of the four slot configuration registers (words 0x018 to 0x01B) keeps mask 0x00010003, independently of the others.
- R8: A mask ID write (word 0x014) ORs the data, masked to 0x00FFFFFF, into the current value. Its bits never clear except by reset.
- R9: A fault event (flt_valid high for one cycle) sets fault status to 0xC0820000, or to 0xC0860000 when flt_is_read is high. It loads fault address with flt_addr with bits 11:0 cleared. irq is high from the next cycle.
- R10: A read or write of fault status or fault address with no fault event in that cycle drops irq on the next edge. An access to any other address leaves irq unchanged.
- R11: When a fault event and a bus write to a fault register fall in the same cycle, the fault values are stored. A fault event in the same cycle as a clearing access leaves irq high.
- R12: A word address that matches no defined register reads back the last value written to it, over the whole 4096-word space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only used for the interrupt clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| flt_valid | input | 1 | One-cycle translation fault event |
| flt_is_read | input | 1 | Failing access was a read |
| flt_addr | input | 32 | Failing DVMA address |
| xlate_en | output | 1 | Translation enable (control bit 0) |
| win_base | output | 32 | Lowest address of the DVMA window |
| pt_base | output | 32 | Page-table base register value |
| irq | output | 1 | Level fault interrupt |

## Verification
The fault capture path and the bus path can both act on the fault registers and the interrupt in one cycle. The bench provokes this by raising flt_valid together with a bus write to the fault address register, and again together with a read of fault status. It judges the first case by reading the fault address back: the value must be the page-aligned fault address, not the bus data. It judges the second case by sampling irq in the following cycle: irq must still be high, and only a later, separate access may clear it.

// File: rtl/iommu_regs_pkg.sv
// Package: register word addresses, write masks and forced bits shared by
// the register bank, the fault unit, the top level and the checker.
// Assumes a 32-bit data path and word addressing.
package iommu_regs_pkg;

    localparam int unsigned DATA_W = 32;

    // Word addresses of the defined registers.
    localparam int unsigned A_CTRL     = 'h000;
    localparam int unsigned A_PTBASE   = 'h001;
    localparam int unsigned A_TLBFLUSH = 'h002;
    localparam int unsigned A_PGFLUSH  = 'h003;
    localparam int unsigned A_FSTAT    = 'h010;
    localparam int unsigned A_FADDR    = 'h011;
    localparam int unsigned A_ARBITER  = 'h012;
    localparam int unsigned A_ARBEN    = 'h013;
    localparam int unsigned A_MASKID   = 'h014;
    localparam int unsigned A_SLOT0    = 'h018;

    // Write masks.
    localparam logic [DATA_W-1:0] M_CTRL    = 32'h0000_001D;
    localparam logic [DATA_W-1:0] M_PTBASE  = 32'h07FF_FC00;
    localparam logic [DATA_W-1:0] M_FSTAT   = 32'hFF0F_FFFF;
    localparam logic [DATA_W-1:0] M_ARBITER = 32'h801F_000F;
    localparam logic [DATA_W-1:0] M_ARBEN   = 32'h001F_0000;
    localparam logic [DATA_W-1:0] M_MASKID  = 32'h00FF_FFFF;
    localparam logic [DATA_W-1:0] M_SLOT    = 32'h0001_0003;

    // Bits that always read as one.
    localparam logic [DATA_W-1:0] F_FSTAT   = 32'h0080_0000;
    localparam logic [DATA_W-1:0] F_ARBITER = 32'h0000_0001;
    localparam logic [DATA_W-1:0] F_ARBEN   = 32'h0000_0008;

    // Reset values that differ from zero (control is built from IMPL_VER).
    localparam logic [DATA_W-1:0] R_ARBITER = 32'h0000_0003;
    localparam logic [DATA_W-1:0] R_MASKID  = 32'h2300_0000;

    // Fault status images: error, late error, forced bit, address valid.
    localparam logic [DATA_W-1:0] FS_BASE   = 32'hC082_0000;
    localparam logic [DATA_W-1:0] FS_READ   = 32'h0004_0000;

    // Range code position inside control.
    localparam int unsigned RANGE_LSB = 2;
    localparam int unsigned RANGE_W   = 3;

endpackage

// File: rtl/iommu_window_decode.sv
// Window decoder: turns the range code into the lowest address of a
// power-of-two window that ends at the top of the address space.
// Assumes MIN_SHIFT + 2**CODE_W - 1 < DATA_W; purely combinational.
module iommu_window_decode #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CODE_W    = 3,
    parameter int unsigned MIN_SHIFT = 24
) (
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] base
);
    localparam int unsigned NCODES = 1 << CODE_W;

    logic [DATA_W-1:0] base_tbl [NCODES];

    // One table entry per code: all ones above the window size.
    for (genvar c = 0; c < NCODES; c++) begin : g_code
        assign base_tbl[c] = {DATA_W{1'b1}} << (MIN_SHIFT + c);
    end

    assign base = base_tbl[code];
endmodule

// File: rtl/iommu_cfg_bank.sv
// Configuration bank: control, page-table base, flush, arbiter,
// arbitration enable, mask ID and slot registers, plus the latched window
// base. Applies each register's write mask and forced bits and provides a
// read mux with a hit flag. Assumes single-cycle writes.
module iommu_cfg_bank
    import iommu_regs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SLOTS     = 4,
    parameter int unsigned MIN_SHIFT = 24,
    parameter logic [7:0]  IMPL_VER  = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hit,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ptb_q,
    output logic [DATA_W-1:0] win_q
);
    localparam logic [DATA_W-1:0] CTRL_RST = {IMPL_VER, {(DATA_W-8){1'b0}}};

    logic [DATA_W-1:0] tlbf_q, pgf_q, arb_q, arben_q, mid_q;
    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [DATA_W-1:0] win_next;
    logic [SLOTS-1:0]  slot_hit;

    logic hit_ctrl, hit_ptb, hit_tlbf, hit_pgf, hit_arb, hit_arben, hit_mid;

    // Address decode of the single registers.
    assign hit_ctrl  = (addr == ADDR_W'(A_CTRL));
    assign hit_ptb   = (addr == ADDR_W'(A_PTBASE));
    assign hit_tlbf  = (addr == ADDR_W'(A_TLBFLUSH));
    assign hit_pgf   = (addr == ADDR_W'(A_PGFLUSH));
    assign hit_arb   = (addr == ADDR_W'(A_ARBITER));
    assign hit_arben = (addr == ADDR_W'(A_ARBEN));
    assign hit_mid   = (addr == ADDR_W'(A_MASKID));

    iommu_window_decode #(
        .DATA_W   (DATA_W),
        .CODE_W   (RANGE_W),
        .MIN_SHIFT(MIN_SHIFT)
    ) u_win (
        .code(wdata[RANGE_LSB +: RANGE_W]),
        .base(win_next)
    );

    // Control register and the window base it selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            win_q  <= '0;
        end else if (wr_en && hit_ctrl) begin
            ctrl_q <= (wdata & M_CTRL) | CTRL_RST;
            win_q  <= win_next;
        end
    end

    // Page-table base and the two flush registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptb_q  <= '0;
            tlbf_q <= '0;
            pgf_q  <= '0;
        end else if (wr_en) begin
            if (hit_ptb)  ptb_q  <= wdata & M_PTBASE;
            if (hit_tlbf) tlbf_q <= wdata;
            if (hit_pgf)  pgf_q  <= wdata;
        end
    end

    // Arbiter enable, arbitration enable and the sticky mask ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q   <= R_ARBITER;
            arben_q <= F_ARBEN;
            mid_q   <= R_MASKID;
        end else if (wr_en) begin
            if (hit_arb)   arb_q   <= (wdata & M_ARBITER) | F_ARBITER;
            if (hit_arben) arben_q <= (wdata & M_ARBEN) | F_ARBEN;
            if (hit_mid)   mid_q   <= mid_q | (wdata & M_MASKID);
        end
    end

    // One masked register per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_hit[g] = (addr == ADDR_W'(A_SLOT0 + g));

        // Slot register g: masked store.
        always_ff @(posedge clk) begin
            if (!rst_n)                     slot_q[g] <= '0;
            else if (wr_en && slot_hit[g])  slot_q[g] <= wdata & M_SLOT;
        end
    end

    // Read mux over the bank and the hit flag for the top-level mux.
    always_comb begin
        rdata = '0;
        hit   = 1'b1;
        if (hit_ctrl)       rdata = ctrl_q;
        else if (hit_ptb)   rdata = ptb_q;
        else if (hit_tlbf)  rdata = tlbf_q;
        else if (hit_pgf)   rdata = pgf_q;
        else if (hit_arb)   rdata = arb_q;
        else if (hit_arben) rdata = arben_q;
        else if (hit_mid)   rdata = mid_q;
        else if (|slot_hit) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_hit[i]) rdata = slot_q[i];
            end
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/iommu_fault_unit.sv
// Fault unit: fault status and fault address registers and the level
// interrupt. A fault event overrides a same-cycle bus write; an access to
// either register clears the interrupt unless a fault arrives in that cycle.
module iommu_fault_unit
    import iommu_regs_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              sel_stat,
    input  logic              sel_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flt_valid,
    input  logic              flt_is_read,
    input  logic [DATA_W-1:0] flt_addr,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] addr_q,
    output logic              irq
);
    localparam logic [DATA_W-1:0] PAGE_MASK = {DATA_W{1'b1}} << PAGE_SHIFT;

    logic clr_access;

    assign clr_access = (wr_en || rd_en) && (sel_stat || sel_addr);

    // Capture on fault, otherwise take masked bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= F_FSTAT;
            addr_q <= '0;
        end else if (flt_valid) begin
            stat_q <= FS_BASE | (flt_is_read ? FS_READ : '0);
            addr_q <= flt_addr & PAGE_MASK;
        end else if (wr_en) begin
            if (sel_stat) stat_q <= (wdata & M_FSTAT) | F_FSTAT;
            if (sel_addr) addr_q <= wdata;
        end
    end

    // Interrupt: set by a fault, cleared by an access to a fault register.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq <= 1'b0;
        else if (flt_valid)  irq <= 1'b1;
        else if (clr_access) irq <= 1'b0;
    end
endmodule

// File: rtl/iommu_scratch.sv
// Scratch store: plain 32-bit words for addresses without a register.
// Assumes the top gates the write strobe; contents are not reset.
module iommu_scratch #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Word store.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/iommu_ctl_regs.sv
// Top: decodes the word address among the configuration bank, the fault
// unit and the scratch store, and multiplexes read data. Read data is
// combinational; all state changes on the rising clock edge.
module iommu_ctl_regs
    import iommu_regs_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned SLOTS      = 4,
    parameter int unsigned MIN_SHIFT  = 24,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter logic [7:0]  IMPL_VER   = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              flt_valid,
    input  logic              flt_is_read,
    input  logic [31:0]       flt_addr,
    output logic              xlate_en,
    output logic [31:0]       win_base,
    output logic [31:0]       pt_base,
    output logic              irq
);
    logic              sel_stat, sel_addr, cfg_hit, scr_wr;
    logic [DATA_W-1:0] cfg_rdata, scr_rdata, stat_q, faddr_q, ctrl_q;

    assign sel_stat = (bus_addr == ADDR_W'(A_FSTAT));
    assign sel_addr = (bus_addr == ADDR_W'(A_FADDR));
    assign scr_wr   = bus_wr && !cfg_hit && !sel_stat && !sel_addr;

    iommu_cfg_bank #(
        .ADDR_W   (ADDR_W),
        .SLOTS    (SLOTS),
        .MIN_SHIFT(MIN_SHIFT),
        .IMPL_VER (IMPL_VER)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (cfg_rdata),
        .hit   (cfg_hit),
        .ctrl_q(ctrl_q),
        .ptb_q (pt_base),
        .win_q (win_base)
    );

    iommu_fault_unit #(
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_flt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .sel_stat   (sel_stat),
        .sel_addr   (sel_addr),
        .wdata      (bus_wdata),
        .flt_valid  (flt_valid),
        .flt_is_read(flt_is_read),
        .flt_addr   (flt_addr),
        .stat_q     (stat_q),
        .addr_q     (faddr_q),
        .irq        (irq)
    );

    iommu_scratch #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_scr (
        .clk  (clk),
        .wr_en(scr_wr),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .rdata(scr_rdata)
    );

    assign xlate_en = ctrl_q[0];

    // Read data select: fault registers, then the bank, then scratch.
    always_comb begin
        if (sel_stat)     bus_rdata = stat_q;
        else if (sel_addr) bus_rdata = faddr_q;
        else if (cfg_hit)  bus_rdata = cfg_rdata;
        else               bus_rdata = scr_rdata;
    end
endmodule

// File: rtl/iommu_ctl_regs_chk.sv
// Checker bound to the top: port-level properties on forced bits, the
// window decode, sticky mask ID and the interrupt set/clear rules.
module iommu_ctl_regs_chk
    import iommu_regs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MIN_SHIFT = 24,
    parameter logic [7:0]  IMPL_VER  = 8'h41
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              flt_valid,
    input logic [31:0]       win_base,
    input logic              irq
);
    logic flt_reg_access;
    assign flt_reg_access = (bus_wr || bus_rd) &&
        (bus_addr == ADDR_W'(A_FSTAT) || bus_addr == ADDR_W'(A_FADDR));

    assert_ctrl_version_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(A_CTRL)) |-> (bus_rdata[31:24] == IMPL_VER));

    assert_window_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_CTRL)) |=>
        (win_base[31] && $countones(win_base) ==
            (32 - int'(MIN_SHIFT) - int'($past(bus_wdata[4:2])))));

    assert_fstat_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(A_FSTAT)) |-> bus_rdata[23]);

    assert_arbiter_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(A_ARBITER)) |-> bus_rdata[0]);

    assert_maskid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(A_MASKID) && $past(bus_addr) == ADDR_W'(A_MASKID)
         && $past(rst_n)) |-> ((bus_rdata & $past(bus_rdata)) == $past(bus_rdata)));

    assert_fault_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> irq);

    assert_access_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_reg_access && !flt_valid) |=> !irq);

    assert_irq_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_reg_access && !flt_valid) |=> $stable(irq));
endmodule

bind iommu_ctl_regs iommu_ctl_regs_chk #(
    .ADDR_W   (ADDR_W),
    .MIN_SHIFT(MIN_SHIFT),
    .IMPL_VER (IMPL_VER)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .flt_valid(flt_valid),
    .win_base (win_base),
    .irq      (irq)
);

// File: tb/iommu_ctl_regs_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected values into a queue, the
// monitor pops and compares them at the falling edge, when outputs are settled.
module iommu_ctl_regs_bench;
    localparam logic [7:0] VER = 8'h41;

    localparam int K_RDATA = 0;
    localparam int K_WIN   = 1;
    localparam int K_PTB   = 2;
    localparam int K_EN    = 3;
    localparam int K_IRQ   = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flt_valid = 1'b0, flt_is_read = 1'b0;
    logic [31:0] flt_addr = '0;
    logic        xlate_en, irq;
    logic [31:0] win_base, pt_base;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb[$];
    item_t cur;
    logic [31:0] act;

    always #2.5 clk = ~clk;

    iommu_ctl_regs #(.IMPL_VER(VER)) u_iommu_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flt_valid(flt_valid), .flt_is_read(flt_is_read), .flt_addr(flt_addr),
        .xlate_en(xlate_en), .win_base(win_base), .pt_base(pt_base), .irq(irq)
    );

    // Monitor: compare every queued expectation against the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            cur = sb.pop_front();
            case (cur.kind)
                K_RDATA: act = bus_rdata;
                K_WIN:   act = win_base;
                K_PTB:   act = pt_base;
                K_EN:    act = {31'b0, xlate_en};
                default: act = {31'b0, irq};
            endcase
            n_chk++;
            if (act !== cur.exp) begin
                n_fail++;
                $display("FAIL %s actual=%08h expected=%08h", cur.tag, act, cur.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    // Read with strobe (may clear irq) and check the returned data.
    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        bus_addr = a; bus_rd = 1'b1;
        sb.push_back('{K_RDATA, e, t});
        step();
        bus_rd = 1'b0;
    endtask

    // Look at an address without the read strobe (no side effect).
    task automatic peek(input logic [11:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        sb.push_back('{K_RDATA, e, t});
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input int k, input logic [31:0] e, input string t);
        sb.push_back('{k, e, t});
        @(negedge clk);
        #1;
    endtask

    task automatic fault(input logic r, input logic [31:0] a);
        flt_valid = 1'b1; flt_is_read = r; flt_addr = a;
        step();
        flt_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1: reset values
        peek(12'h000, {VER, 24'h0}, "R1 ctrl");
        peek(12'h001, 32'h0, "R1 ptbase");
        peek(12'h010, 32'h0080_0000, "R1 fstat");
        peek(12'h011, 32'h0, "R1 faddr");
        peek(12'h012, 32'h0000_0003, "R1 arbiter");
        peek(12'h013, 32'h0000_0008, "R1 arben");
        peek(12'h014, 32'h2300_0000, "R1 maskid");
        peek(12'h01A, 32'h0, "R1 slot2");
        chk(K_WIN, 32'h0, "R1 win_base");
        chk(K_EN, 32'h0, "R1 xlate_en");
        chk(K_IRQ, 32'h0, "R1 irq");

        // R2: control mask and version
        wr(12'h000, 32'hFFFF_FFFF);
        peek(12'h000, {VER, 24'h1D}, "R2 ctrl all ones");
        chk(K_EN, 32'h1, "R2 xlate_en set");
        chk(K_WIN, 32'h8000_0000, "R3 code 7");
        wr(12'h000, 32'h0000_0002);
        peek(12'h000, {VER, 24'h00}, "R2 ctrl bit1 dropped");
        chk(K_EN, 32'h0, "R2 xlate_en clear");

        // R3: every range code
        for (int c = 0; c < 8; c++) begin
            wr(12'h000, 32'(c) << 2);
            chk(K_WIN, 32'hFFFF_FFFF << (24 + c), "R3 range code");
        end

        // R4: page-table base and flush registers
        wr(12'h001, 32'hFFFF_FFFF);
        peek(12'h001, 32'h07FF_FC00, "R4 ptbase mask");
        chk(K_PTB, 32'h07FF_FC00, "R4 pt_base port");
        wr(12'h002, 32'hDEAD_BEEF);
        peek(12'h002, 32'hDEAD_BEEF, "R4 tlb flush");
        wr(12'h003, 32'h1234_5678);
        peek(12'h003, 32'h1234_5678, "R4 page flush");

        // R5: fault status and fault address writes
        wr(12'h010, 32'h0);
        peek(12'h010, 32'h0080_0000, "R5 fstat zero");
        wr(12'h010, 32'hFFFF_FFFF);
        peek(12'h010, 32'hFF8F_FFFF, "R5 fstat ones");
        wr(12'h011, 32'hA5A5_5A5A);
        peek(12'h011, 32'hA5A5_5A5A, "R5 faddr");

        // R6: arbiter and arbitration enable
        wr(12'h012, 32'h0);
        peek(12'h012, 32'h0000_0001, "R6 arbiter zero");
        wr(12'h012, 32'hFFFF_FFFF);
        peek(12'h012, 32'h801F_000F, "R6 arbiter ones");
        wr(12'h013, 32'h0);
        peek(12'h013, 32'h0000_0008, "R6 arben zero");
        wr(12'h013, 32'hFFFF_FFFF);
        peek(12'h013, 32'h001F_0008, "R6 arben ones");

        // R7: slot registers, each independent
        wr(12'h019, 32'hFFFF_FFFF);
        peek(12'h019, 32'h0001_0003, "R7 slot1 ones");
        peek(12'h018, 32'h0, "R7 slot0 untouched");
        peek(12'h01B, 32'h0, "R7 slot3 untouched");
        wr(12'h01B, 32'h0001_0002);
        peek(12'h01B, 32'h0001_0002, "R7 slot3");

        // R8: sticky mask ID
        wr(12'h014, 32'h0000_00F0);
        peek(12'h014, 32'h2300_00F0, "R8 first or");
        wr(12'h014, 32'h0000_000F);
        peek(12'h014, 32'h2300_00FF, "R8 second or");
        wr(12'h014, 32'hFF00_0000);
        peek(12'h014, 32'h2300_00FF, "R8 high bits ignored");

        // R9: fault capture, read then write kind
        fault(1'b1, 32'h1234_5678);
        chk(K_IRQ, 32'h1, "R9 irq raised");
        peek(12'h010, 32'hC086_0000, "R9 fstat read fault");
        peek(12'h011, 32'h1234_5000, "R9 faddr page");
        // R10: unrelated access leaves irq high, fault-register read clears it
        rd(12'h013, 32'h001F_0008, "R10 other read");
        chk(K_IRQ, 32'h1, "R10 irq kept");
        rd(12'h011, 32'h1234_5000, "R10 faddr read");
        chk(K_IRQ, 32'h0, "R10 irq cleared by read");
        fault(1'b0, 32'hABCD_EFFF);
        peek(12'h010, 32'hC082_0000, "R9 fstat write fault");
        peek(12'h011, 32'hABCD_E000, "R9 faddr write fault");
        wr(12'h010, 32'h0);
        chk(K_IRQ, 32'h0, "R10 irq cleared by write");

        // R11: fault against a same-cycle write of fault address
        flt_valid = 1'b1; flt_is_read = 1'b0; flt_addr = 32'h0000_7ABC;
        bus_addr = 12'h011; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        step();
        flt_valid = 1'b0; bus_wr = 1'b0;
        peek(12'h011, 32'h0000_7000, "R11 fault beats write");
        chk(K_IRQ, 32'h1, "R11 irq after collision");
        // R11: fault against a same-cycle read of fault status
        rd(12'h010, 32'hC082_0000, "R11 fstat");
        flt_valid = 1'b1; flt_is_read = 1'b1; flt_addr = 32'h0000_3000;
        bus_addr = 12'h010; bus_rd = 1'b1;
        step();
        flt_valid = 1'b0; bus_rd = 1'b0;
        chk(K_IRQ, 32'h1, "R11 irq held");
        rd(12'h010, 32'hC086_0000, "R11 fstat second");
        chk(K_IRQ, 32'h0, "R11 later clear");

        // R12: scratch storage
        wr(12'h100, 32'hCAFE_F00D);
        wr(12'hFFF, 32'h0000_0001);
        wr(12'h004, 32'h5555_AAAA);
        peek(12'h100, 32'hCAFE_F00D, "R12 word 0x100");
        peek(12'hFFF, 32'h0000_0001, "R12 top word");
        peek(12'h004, 32'h5555_AAAA, "R12 gap word");

        step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule